// File: doc/BRIEF.md
# Bit Permutation Unit

A purely combinational 32-bit datapath for a group of bit-manipulation operations: logical right and left shifts, generalized reverse, generalized or-combine, and generalized shuffle and unshuffle (zip and unzip). Operand A carries the data. The low bits of operand B carry the shift amount or the permutation control. A 3-bit select picks the operation. The result appears on the output in the same cycle, so the unit can sit directly inside an execute stage. Immediate forms of the operations reuse it, with B taken from the immediate.

Only one right shifter exists. A left shift bit-reverses the operand, shifts it right, and then reverses it back. The back-reversal is built from the five block-swap stages that also implement reverse and or-combine. Every one of those stages is forced on for a left shift.

Shuffle and unshuffle share one network of four swap stages, placed between two flip stages. For unshuffle the flips are active and the control bits are taken in the opposite order. The same stages then apply the inverse permutation.

Top module: `bperm_unit`

## Requirements
- R1: opSel 3'd0 gives a logical right shift of opA by opB[4:0], filling with zeros.
- R2: opSel 3'd1 gives a logical left shift of opA by opB[4:0], filling with zeros.
- R3: opSel 3'd2 (generalized reverse) gives result[i] = opA[i XOR opB[4:0]]. With opB[4:0] = 31 the whole word is bit-reversed.
- R4: opSel 3'd3 (generalized or-combine) gives result[i] = the OR of opA[i XOR m] over every m whose set bits are a subset of opB[4:0]. With opB[4:0] = 7, each byte of opA that holds any set bit becomes 8'hFF, and each zero byte stays 8'h00.
- R5: opSel 3'd4 (shuffle) uses opB[3:0]. It moves bit n to position p, where p is n with index bits (i, i+1) swapped for each set control bit i, taken in the order i = 3, 2, 1, 0. With opB[3:0] = 15, the lower half of the word lands in the even positions and the upper half in the odd positions.
- R6: opSel 3'd5 (unshuffle) is the exact inverse of shuffle for the same opB[3:0]: the index swaps are applied in the order i = 0, 1, 2, 3. For every A and control value, unshuffle(shuffle(A)) = A.
- R7: Bits of opB above bit 4 have no effect on any operation. For shuffle and unshuffle, bit 4 has no effect either.
- R8: opSel values 3'd6 and 3'd7 give a result of zero.
- R9: Reverse, shuffle and unshuffle are permutations: the result has the same number of set bits as opA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | Data operand |
| opB | input | 32 | Shift amount or permutation control (low bits used) |
| opSel | input | 3 | Operation select (encoding in R1 to R8) |
| result | output | 32 | Combinational result |

## Verification
The bench steps every operation through all 32 low control values, with random data and random upper bits of B. Any dependence on bits outside the control field therefore shows up as a mismatch. Specific failures it targets:
- A swapped control order in the shuffle network, or flip stages left active for shuffle, would break the half-interleave pattern.
- An unshuffle that fails to invert the control order would not return the original word.
- A left shift without the forced back-reversal stages would come out mirrored.
- An or-combine that replaces bits instead of OR-ing them would lose bits within each byte.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

  typedef enum logic [2:0] {
    OP_SRL    = 3'd0,
    OP_SLL    = 3'd1,
    OP_GREV   = 3'd2,
    OP_GORC   = 3'd3,
    OP_SHFL   = 3'd4,
    OP_UNSHFL = 3'd5
  } bperm_op_e;

  typedef struct packed {
    logic shiftLeft;   // reverse around the shifter, force all butterfly stages
    logic shiftEn;     // right shifter active
    logic bflyEn;      // butterfly stages follow control bits
    logic orComb;      // butterfly stages OR instead of replace
    logic shufSel;     // pick shuffle network output
    logic unshuf;      // flips active, control order inverted
    logic zeroOut;     // reserved select
  } bperm_ctl_t;

endpackage

// File: rtl/bperm_ctrl.sv
module bperm_ctrl
  import bperm_pkg::*;
(
  input  logic [2:0] opSel,
  output bperm_ctl_t ctl
);

  always_comb begin
    ctl = '0;
    case (opSel)
      OP_SRL:    ctl.shiftEn = 1'b1;
      OP_SLL: begin
        ctl.shiftEn   = 1'b1;
        ctl.shiftLeft = 1'b1;
      end
      OP_GREV:   ctl.bflyEn = 1'b1;
      OP_GORC: begin
        ctl.bflyEn = 1'b1;
        ctl.orComb = 1'b1;
      end
      OP_SHFL:   ctl.shufSel = 1'b1;
      OP_UNSHFL: begin
        ctl.shufSel = 1'b1;
        ctl.unshuf  = 1'b1;
      end
      default:   ctl.zeroOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/bperm_datapath.sv
module bperm_datapath
  import bperm_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int LOG2W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [LOG2W-1:0] amt,
  input  bperm_ctl_t       ctl,
  output logic [WIDTH-1:0] result
);

  localparam int NSHF = LOG2W - 1;

  function automatic logic [WIDTH-1:0] bitRev(input logic [WIDTH-1:0] x);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = x[WIDTH-1-i];
    return r;
  endfunction

  // position n moves to the index whose LOG2W bits are n's bits reversed
  function automatic logic [WIDTH-1:0] flipPerm(input logic [WIDTH-1:0] x);
    logic [WIDTH-1:0] r;
    for (int n = 0; n < WIDTH; n++) begin
      int p;
      p = 0;
      for (int j = 0; j < LOG2W; j++)
        if (((n >> j) & 1) != 0) p = p | (1 << (LOG2W-1-j));
      r[p] = x[n];
    end
    return r;
  endfunction

  // swap index bits h and h+1: middle quarters of each 2^(h+2) group trade places
  function automatic logic [WIDTH-1:0] shufStage(input logic [WIDTH-1:0] x, input int h);
    logic [WIDTH-1:0] r;
    for (int n = 0; n < WIDTH; n++) begin
      int lo, hi, p;
      lo = (n >> h) & 1;
      hi = (n >> (h+1)) & 1;
      p  = (n & ~(3 << h)) | (lo << (h+1)) | (hi << h);
      r[p] = x[n];
    end
    return r;
  endfunction

  // shared right shifter with optional reversal in front
  logic [WIDTH-1:0] shIn, shOut;
  assign shIn  = ctl.shiftLeft ? bitRev(opA) : opA;
  assign shOut = ctl.shiftEn ? (shIn >> amt) : shIn;

  // butterfly stages: reverse, or-combine, and back-reversal for left shifts
  genvar k;
  generate
    for (k = 0; k < LOG2W; k++) begin : gBfly
      logic [WIDTH-1:0] stIn, swapped, stOut;
      logic stEn;
      if (k == 0) begin : gFirst
        assign stIn = shOut;
      end else begin : gNext
        assign stIn = gBfly[k-1].stOut;
      end
      for (genvar i = 0; i < WIDTH; i++) begin : gBit
        localparam int J = i ^ (1 << k);
        assign swapped[i] = stIn[J];
      end
      assign stEn  = (ctl.bflyEn & amt[k]) | ctl.shiftLeft;
      assign stOut = !stEn ? stIn : (ctl.orComb ? (stIn | swapped) : swapped);
    end
  endgenerate

  // shuffle network: flip, NSHF swap stages, flip
  logic [WIDTH-1:0] flipIn, shufOut;
  assign flipIn = ctl.unshuf ? flipPerm(opA) : opA;

  genvar s;
  generate
    for (s = 0; s < NSHF; s++) begin : gShuf
      localparam int H = NSHF - 1 - s;
      logic [WIDTH-1:0] sIn, sOut;
      logic sEn;
      if (s == 0) begin : gFirst
        assign sIn = flipIn;
      end else begin : gNext
        assign sIn = gShuf[s-1].sOut;
      end
      assign sEn  = ctl.unshuf ? amt[s] : amt[H];
      assign sOut = sEn ? shufStage(sIn, H) : sIn;
    end
  endgenerate

  assign shufOut = ctl.unshuf ? flipPerm(gShuf[NSHF-1].sOut) : gShuf[NSHF-1].sOut;

  assign result = ctl.zeroOut ? '0 :
                  ctl.shufSel ? shufOut : gBfly[LOG2W-1].stOut;

endmodule

// File: rtl/bperm_unit.sv
module bperm_unit
  import bperm_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int LOG2W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] result
);

  bperm_ctl_t ctl;
  logic unusedHighB;
  assign unusedHighB = ^opB[WIDTH-1:LOG2W];

  bperm_ctrl ctrl_i (
    .opSel (opSel),
    .ctl   (ctl)
  );

  bperm_datapath #(.WIDTH(WIDTH)) dp_i (
    .opA    (opA),
    .amt    (opB[LOG2W-1:0]),
    .ctl    (ctl),
    .result (result)
  );

endmodule

// File: rtl/bperm_unit_chk.sv
module bperm_unit_chk #(
  parameter int WIDTH = 32,
  localparam int LOG2W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] result
);

  function automatic logic [WIDTH-1:0] mirror(input logic [WIDTH-1:0] x);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = x[WIDTH-1-i];
    return r;
  endfunction

  logic known;
  assign known = !$isunknown({opA, opB, opSel, result});

  always_comb begin
    if (known) begin
      if (opSel == 3'd0)
        assert_srl_fill_R1: assert (result == (opA >> opB[LOG2W-1:0]))
          else $error("R1 right shift mismatch");
      if (opSel == 3'd1)
        assert_sll_fill_R2: assert (result == (opA << opB[LOG2W-1:0]))
          else $error("R2 left shift mismatch");
      if (opSel == 3'd2 && (&opB[LOG2W-1:0]))
        assert_grev_full_R3: assert (result == mirror(opA))
          else $error("R3 full reverse mismatch");
      if (opSel == 3'd3)
        assert_gorc_superset_R4: assert ((result & opA) == opA)
          else $error("R4 or-combine dropped a bit");
      if ((opSel == 3'd4 || opSel == 3'd5) && opB[LOG2W-2:0] == '0)
        assert_shuf_identity_R5: assert (result == opA)
          else $error("R5/R6 zero control not identity");
      if (opSel == 3'd6 || opSel == 3'd7)
        assert_reserved_zero_R8: assert (result == '0)
          else $error("R8 reserved select not zero");
      if (opSel == 3'd2 || opSel == 3'd4 || opSel == 3'd5)
        assert_popcount_kept_R9: assert ($countones(result) == $countones(opA))
          else $error("R9 set-bit count changed");
    end
  end

endmodule

bind bperm_unit bperm_unit_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/bperm_unit_tb_top.sv
module bperm_unit_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [31:0] opA, opB, result;
  logic [2:0]  opSel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bperm_unit dut_i (.opA(opA), .opB(opB), .opSel(opSel), .result(result));

  function automatic int swapIdx(int p, int i);
    int lo, hi;
    lo = (p >> i) & 1;
    hi = (p >> (i+1)) & 1;
    return (p & ~(3 << i)) | (lo << (i+1)) | (hi << i);
  endfunction

  function automatic logic [31:0] refModel(int op, logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    int k, c;
    k = int'(b[4:0]);
    c = int'(b[3:0]);
    r = '0;
    case (op)
      0: r = a >> k;
      1: r = a << k;
      2: for (int i = 0; i < 32; i++) r[i] = a[i ^ k];
      3: for (int i = 0; i < 32; i++)
           for (int m = 0; m < 32; m++)
             if ((m & ~k) == 0) r[i] = r[i] | a[i ^ m];
      4: for (int n = 0; n < 32; n++) begin
           int p;
           p = n;
           for (int i = 3; i >= 0; i--) if (((c >> i) & 1) != 0) p = swapIdx(p, i);
           r[p] = a[n];
         end
      5: for (int n = 0; n < 32; n++) begin
           int p;
           p = n;
           for (int i = 0; i <= 3; i++) if (((c >> i) & 1) != 0) p = swapIdx(p, i);
           r[p] = a[n];
         end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tagOf(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(int op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    opSel = op[2:0];
    opA = a;
    opB = b;
    #1;
  endtask

  initial begin
    opA = '0; opB = '0; opSel = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // reset state: zero operands give zero
    apply(0, 32'h0, 32'h0);
    check("R1 idle", result, 32'h0);

    // directed boundary cases
    apply(2, 32'h12345678, 32'h0000001F);
    check("R3 full reverse", result, 32'h1E6A2C48);
    apply(3, 32'h00010080, 32'h00000007);
    check("R4 byte combine", result, 32'h00FF00FF);
    apply(4, 32'h0000FFFF, 32'h0000000F);
    check("R5 zip halves", result, 32'h55555555);
    apply(5, 32'h55555555, 32'h0000000F);
    check("R6 unzip", result, 32'h0000FFFF);
    apply(1, 32'h80000001, 32'h0000001F);
    check("R2 max left", result, 32'h80000000);
    apply(0, 32'h80000001, 32'h0000001F);
    check("R1 max right", result, 32'h00000001);
    apply(6, 32'hFFFFFFFF, 32'h0000001F);
    check("R8 select 6", result, 32'h0);
    apply(7, 32'hFFFFFFFF, 32'h00000003);
    check("R8 select 7", result, 32'h0);

    // exhaustive low control, random data and upper B bits (R7)
    for (int op = 0; op < 8; op++) begin
      for (int c = 0; c < 32; c++) begin
        for (int t = 0; t < 3; t++) begin
          logic [31:0] a, b;
          a = (t == 0) ? 32'hA5C3_0F18 : $urandom;
          b = {$urandom, 5'b0} | c;
          apply(op, a, b);
          check(tagOf(op), result, refModel(op, a, b));
          if (t == 2) begin
            logic [31:0] base;
            base = result;
            apply(op, a, {27'h0, b[4:0] ^ ((op == 4 || op == 5) ? 5'h10 : 5'h0)});
            check("R7 upper B ignored", result, base);
          end
          if (op == 2 || op == 4 || op == 5)
            check("R9 bit count", 32'($countones(result)), 32'($countones(a)));
        end
      end
    end

    // round trip through shuffle then unshuffle (R6)
    for (int c = 0; c < 16; c++) begin
      logic [31:0] a, mid;
      a = $urandom;
      apply(4, a, 32'(c));
      mid = result;
      apply(5, mid, 32'(c));
      check("R6 round trip", result, a);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule